// File: doc/BRIEF.md
# I2C Control and Status Register Unit

This block is the register side of an I2C controller. Software sees a five-bit control word. It never writes that word directly. One bus address sets every control bit that has a one in the written byte. A second address clears every control bit that has a one in the written byte. The word holds the interface enable, the start request, the stop request, the serial interrupt flag and the acknowledge-select bit. Each of these bits is also driven out to the protocol engine.

The protocol engine sits outside this block. It reports each new bus state as a five-bit code together with a one-cycle interrupt-set strobe, and it pulses separate strobes once a start or a stop condition has gone out on the bus. The unit places the code in the top five bits of a byte-wide status register. That byte holds steady for as long as the interrupt flag is pending. Consecutive codes therefore read eight apart, and the byte returns to 0xF8 once nothing is pending. The interrupt request output is the AND of the flag and the enable bit.

Top module: `i2c_csr_top`

## Requirements
- R1: After reset the control word reads 0x00, the status byte reads 0xF8 and irq is low.
- R2: A write to address 0 ORs the low five bits of the written byte into the control word and leaves the other bits as they were. Bits 7:5 of the control word always read as zero, whatever is written.
- R3: A write to address 2 clears each control bit whose position holds a one in the written byte and leaves every other bit as it was.
- R4: A read of address 0 returns the control word with enable in bit 0, start in bit 1, stop in bit 2, interrupt flag in bit 3 and acknowledge in bit 4. A read of address 2 or 3 returns 0x00.
- R5: A read of address 1 returns the status byte, with the bus-state code in bits 7:3 and zeros in bits 2:0.
- R6: When the interrupt flag is clear, an interrupt-set strobe sets the flag and latches the code. Both are visible from the next clock edge.
- R7: While the flag is pending and no clear of it is written, further interrupt-set strobes leave the status byte unchanged and the flag set.
- R8: While the flag is clear, the status byte reads 0xF8. Clearing the flag returns it to 0xF8.
- R9: If an interrupt-set strobe arrives in the same cycle as a write that clears the flag, the flag stays set and the new code is latched.
- R10: A start-done strobe clears the start bit and a stop-done strobe clears the stop bit, unless a write to address 0 sets that same bit in the same cycle. In that case the bit stays set.
- R11: irq is high exactly when both the interrupt flag and the enable bit are set.
- R12: The outputs ctrl_en, ctrl_start, ctrl_stop and ctrl_ack follow their control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | 0 set port / control read, 1 status, 2 clear port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| eng_int_set | input | 1 | Engine strobe: new bus state ready |
| eng_status | input | 5 | Bus-state code from the engine |
| eng_start_done | input | 1 | Engine strobe: start condition sent |
| eng_stop_done | input | 1 | Engine strobe: stop condition sent |
| ctrl_en | output | 1 | Interface enable bit |
| ctrl_start | output | 1 | Start request bit |
| ctrl_stop | output | 1 | Stop request bit |
| ctrl_ack | output | 1 | Acknowledge-select bit |
| irq | output | 1 | Interrupt request |

## Verification
Reads are combinational, so a read result is due in the same cycle that the address is driven. Every write and every engine strobe changes the registers at the one clock edge that follows it, and irq and the ctrl outputs follow one edge after their cause. The bench drives each stimulus on a falling edge and holds it across exactly one rising edge. It removes the stimulus on the next falling edge and samples there or later, so each check falls one edge after its cause. Same-cycle collisions, such as a strobe against a clearing write or a done strobe against a setting write, are driven in a single cycle to exercise the priority rules.

// File: rtl/i2c_csr_pkg.sv
package i2c_csr_pkg;

    localparam int DATA_W = 8;
    localparam int CODE_W = 5;
    localparam int ADDR_W = 2;
    localparam int CTRL_W = 5;
    localparam int LSB_W  = DATA_W - CODE_W;

    // Bit positions of the control word (read back at the set address)
    localparam int B_EN  = 0;
    localparam int B_STA = 1;
    localparam int B_STO = 2;
    localparam int B_INT = 3;
    localparam int B_ACK = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_SET  = 2'd0,
        A_STAT = 2'd1,
        A_CLR  = 2'd2,
        A_NONE = 2'd3
    } addr_e;

    // Packed MSB first: ack is bit 4, en is bit 0
    typedef struct packed {
        logic ack;
        logic intf;
        logic sto;
        logic sta;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic [CTRL_W-1:0] set_m;
        logic [CTRL_W-1:0] clr_m;
    } wreq_t;

    localparam logic [CODE_W-1:0] IDLE_CODE = '1;

    function automatic logic [DATA_W-1:0] stat_byte(input logic [CODE_W-1:0] c);
        return {c, {LSB_W{1'b0}}};
    endfunction

endpackage

// File: rtl/i2c_csr_regif.sv
module i2c_csr_regif
    import i2c_csr_pkg::*;
(
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  ctrl_t                ctrl_q,
    input  logic [CODE_W-1:0]    stat_code,
    output wreq_t                wreq,
    output logic [DATA_W-1:0]    bus_rdata
);

    logic wr_hit;
    logic unused_hi;

    assign wr_hit    = bus_sel && bus_wr;
    assign unused_hi = ^bus_wdata[DATA_W-1:CTRL_W];

    always_comb begin
        wreq = '0;
        if (wr_hit && addr_e'(bus_addr) == A_SET) wreq.set_m = bus_wdata[CTRL_W-1:0];
        if (wr_hit && addr_e'(bus_addr) == A_CLR) wreq.clr_m = bus_wdata[CTRL_W-1:0];
    end

    always_comb begin
        case (addr_e'(bus_addr))
            A_SET:   bus_rdata = DATA_W'(ctrl_q);
            A_STAT:  bus_rdata = stat_byte(stat_code);
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/i2c_csr_ctrl.sv
module i2c_csr_ctrl
    import i2c_csr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  wreq_t  wreq,
    input  logic   hw_int_set,
    input  logic   start_done,
    input  logic   stop_done,
    output ctrl_t  ctrl_q
);

    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_t'((CTRL_W'(ctrl_q) | wreq.set_m) & ~wreq.clr_m);
        if (start_done && !wreq.set_m[B_STA]) ctrl_d.sta = 1'b0;
        if (stop_done  && !wreq.set_m[B_STO]) ctrl_d.sto = 1'b0;
        if (hw_int_set) ctrl_d.intf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

endmodule

// File: rtl/i2c_csr_stat.sv
module i2c_csr_stat
    import i2c_csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               intf_q,
    input  logic               clr_intf,
    input  logic               hw_int_set,
    input  logic [CODE_W-1:0]  hw_code,
    output logic [CODE_W-1:0]  stat_code
);

    logic load;
    logic to_idle;

    assign load    = hw_int_set && (!intf_q || clr_intf);
    assign to_idle = clr_intf && !hw_int_set;

    always_ff @(posedge clk) begin
        if (rst)          stat_code <= IDLE_CODE;
        else if (load)    stat_code <= hw_code;
        else if (to_idle) stat_code <= IDLE_CODE;
    end

endmodule

// File: rtl/i2c_csr_top.sv
module i2c_csr_top
    import i2c_csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               eng_int_set,
    input  logic [CODE_W-1:0]  eng_status,
    input  logic               eng_start_done,
    input  logic               eng_stop_done,
    output logic               ctrl_en,
    output logic               ctrl_start,
    output logic               ctrl_stop,
    output logic               ctrl_ack,
    output logic               irq
);

    wreq_t             wreq;
    ctrl_t             ctrl_q;
    logic [CODE_W-1:0] stat_code;

    i2c_csr_regif u_regif (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ctrl_q    (ctrl_q),
        .stat_code (stat_code),
        .wreq      (wreq),
        .bus_rdata (bus_rdata)
    );

    i2c_csr_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wreq       (wreq),
        .hw_int_set (eng_int_set),
        .start_done (eng_start_done),
        .stop_done  (eng_stop_done),
        .ctrl_q     (ctrl_q)
    );

    i2c_csr_stat u_stat (
        .clk        (clk),
        .rst        (rst),
        .intf_q     (ctrl_q.intf),
        .clr_intf   (wreq.clr_m[B_INT]),
        .hw_int_set (eng_int_set),
        .hw_code    (eng_status),
        .stat_code  (stat_code)
    );

    assign ctrl_en    = ctrl_q.en;
    assign ctrl_start = ctrl_q.sta;
    assign ctrl_stop  = ctrl_q.sto;
    assign ctrl_ack   = ctrl_q.ack;
    assign irq        = ctrl_q.intf && ctrl_q.en;

endmodule

// File: rtl/i2c_csr_chk.sv
module i2c_csr_chk
    import i2c_csr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               eng_int_set,
    input logic [CODE_W-1:0]  eng_status,
    input logic               eng_start_done,
    input logic               ctrl_start,
    input logic               ctrl_en,
    input logic               irq,
    input logic               intf,
    input logic [CODE_W-1:0]  stat_code
);

    logic set_wr;
    logic clr_wr;
    assign set_wr = bus_sel && bus_wr && bus_addr == 2'd0;
    assign clr_wr = bus_sel && bus_wr && bus_addr == 2'd2;

    p_status_low_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && bus_addr == 2'd1) |-> bus_rdata[LSB_W-1:0] == '0);

    p_status_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (intf && !(clr_wr && bus_wdata[B_INT])) |=> $stable(stat_code));

    p_idle_code_r8: assert property (@(posedge clk) disable iff (rst)
        !intf |-> stat_code == IDLE_CODE);

    p_hw_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (eng_int_set && clr_wr && bus_wdata[B_INT]) |=> (intf && stat_code == $past(eng_status)));

    p_start_done_r10: assert property (@(posedge clk) disable iff (rst)
        (eng_start_done && !(set_wr && bus_wdata[B_STA])) |=> !ctrl_start);

    p_irq_needs_en_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> ctrl_en);

    p_set_en_r2: assert property (@(posedge clk) disable iff (rst)
        (set_wr && bus_wdata[B_EN]) |=> ctrl_en);

endmodule

bind i2c_csr_top i2c_csr_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_sel        (bus_sel),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .eng_int_set    (eng_int_set),
    .eng_status     (eng_status),
    .eng_start_done (eng_start_done),
    .ctrl_start     (ctrl_start),
    .ctrl_en        (ctrl_en),
    .irq            (irq),
    .intf           (ctrl_q.intf),
    .stat_code      (stat_code)
);

// File: tb/sim_i2c_csr_top.sv
module sim_i2c_csr_top;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd3;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       eng_int_set = 1'b0;
    logic [4:0] eng_status = 5'h00;
    logic       eng_start_done = 1'b0;
    logic       eng_stop_done = 1'b0;
    logic       ctrl_en, ctrl_start, ctrl_stop, ctrl_ack, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    i2c_csr_top u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_int_set(eng_int_set), .eng_status(eng_status),
        .eng_start_done(eng_start_done), .eng_stop_done(eng_stop_done),
        .ctrl_en(ctrl_en), .ctrl_start(ctrl_start), .ctrl_stop(ctrl_stop),
        .ctrl_ack(ctrl_ack), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd3; bus_wdata = 8'h00;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0; bus_addr = 2'd3;
    endtask

    task automatic hw_set(input logic [4:0] c);
        @(negedge clk);
        eng_int_set = 1'b1; eng_status = c;
        @(negedge clk);
        eng_int_set = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(2'd0, v); check("R1 control after reset", v, 8'h00);
        rd(2'd1, v); check("R1 status after reset", v, 8'hF8);
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
        rd(2'd2, v); check("R4 clear address reads zero", v, 8'h00);
    endtask

    task automatic t_set_clear;
        logic [7:0] v;
        wr(2'd0, 8'h11);
        rd(2'd0, v); check("R2 set en+ack", v, 8'h11);
        check("R12 ctrl_en/ctrl_ack", {6'd0, ctrl_en, ctrl_ack}, 8'h03);
        wr(2'd0, 8'hE0);
        rd(2'd0, v); check("R2 reserved bits stay zero", v, 8'h11);
        wr(2'd2, 8'h10);
        rd(2'd0, v); check("R3 clear ack only", v, 8'h01);
        wr(2'd2, 8'h00);
        rd(2'd0, v); check("R3 zero clear no effect", v, 8'h01);
        rd(2'd3, v); check("R4 unused address reads zero", v, 8'h00);
    endtask

    task automatic t_capture;
        logic [7:0] v;
        hw_set(5'h01);
        rd(2'd0, v); check("R6 flag set by strobe", v, 8'h09);
        rd(2'd1, v); check("R5 status byte code 1", v, 8'h08);
        check("R11 irq with flag and enable", {7'd0, irq}, 8'h01);
    endtask

    task automatic t_freeze;
        logic [7:0] v;
        hw_set(5'h05);
        rd(2'd1, v); check("R7 status frozen while pending", v, 8'h08);
        rd(2'd0, v); check("R7 flag still set", v, 8'h09);
        wr(2'd2, 8'h08);
        rd(2'd1, v); check("R8 status idle after clear", v, 8'hF8);
        check("R11 irq low after clear", {7'd0, irq}, 8'h00);
        hw_set(5'h1A);
        rd(2'd1, v); check("R5 status byte code 0x1A", v, 8'hD0);
    endtask

    task automatic t_tie;
        logic [7:0] v;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h08;
        eng_int_set = 1'b1; eng_status = 5'h03;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd3; bus_wdata = 8'h00;
        eng_int_set = 1'b0;
        rd(2'd0, v); check("R9 flag kept on tie", v, 8'h09);
        rd(2'd1, v); check("R9 new code latched on tie", v, 8'h18);
        wr(2'd2, 8'h08);
    endtask

    task automatic t_irq_enable;
        logic [7:0] v;
        wr(2'd2, 8'h01);
        hw_set(5'h02);
        rd(2'd0, v); check("R11 flag set, enable off", v, 8'h08);
        check("R11 irq low without enable", {7'd0, irq}, 8'h00);
        wr(2'd0, 8'h01);
        check("R11 irq high after enable", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'h08);
        rd(2'd1, v); check("R8 idle again", v, 8'hF8);
    endtask

    task automatic t_done;
        logic [7:0] v;
        wr(2'd0, 8'h06);
        check("R12 start/stop outputs", {6'd0, ctrl_start, ctrl_stop}, 8'h03);
        @(negedge clk); eng_start_done = 1'b1;
        @(negedge clk); eng_start_done = 1'b0;
        check("R10 start cleared by done", {6'd0, ctrl_start, ctrl_stop}, 8'h01);
        @(negedge clk); eng_stop_done = 1'b1;
        @(negedge clk); eng_stop_done = 1'b0;
        rd(2'd0, v); check("R10 stop cleared by done", v, 8'h01);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h02;
        eng_start_done = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd3; bus_wdata = 8'h00;
        eng_start_done = 1'b0;
        check("R10 set write beats start done", {7'd0, ctrl_start}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_set_clear();
        t_capture();
        t_freeze();
        t_tie();
        t_irq_enable();
        t_done();
        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule